// File: doc/BRIEF.md
# Microcoded Control Sequencer with Exception Branches

This block is the control sequencer of a multicycle processor. A micro-program counter (micro-PC) holds the address of the current microinstruction in an internal control store. Each cycle, a two-bit sequencing field in that microinstruction picks the next address. The choices are back to the fetch word, through an opcode-indexed dispatch table, or on to the next word. Every field of the current microinstruction is exported as a registered control output for the datapath, which sits outside this block.

Two extra paths can take a cycle away from the normal flow:

- **Condition-select branch.** A condition-select field lets one flag override the sequencing choice. The ALU overflow flag is tested after an R-type operation. The pending-interrupt flag is tested in the last word of every instruction, before the next fetch.
- **Trap dispatch.** Any opcode the dispatch table does not know is routed to a trap routine.

The overflow, interrupt and trap routines each live at a dedicated address. Each one reports a cause code and then returns to fetch. All pins are plain control signals: there is no stream traffic and no back-pressure.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and the control outputs show the fetch word (see R2). This holds again whenever reset is re-asserted in the middle of an instruction.
- R2: The word at address 0 is the fetch word. Its fields are alu_op=00 (add), src1_sel=0 (PC), src2_sel=000 (constant 4), mem_op=01 (read at PC), ir_wr=1, pc_wr=01 (PC from ALU), seq_code=10, cond_code=00 and cause_we=0. The next address is always 1, and both flags are ignored there.
- R3: When no branch is taken, seq_code 00 sends the micro-PC to 0, 01 sends it to the dispatch-table result, and 10 sends it to the current address + 1.
- R4: Dispatch at the decode word (address 1) maps opcodes to start addresses as follows: 0x00 (R-type) to 4, 0x04 (BEQ) to 2, 0x0D (ORI) to 6, 0x23 (LW) to 8, 0x2B (SW) to 11, and 0x02 (jump) to 3.
- R5: Every other opcode dispatches to the trap word at address 16. That word shows cause_we=1 and cause_val=10, and it returns to 0 on the next cycle.
- R6: At address 4 (R-type ALU step, cond_code=01), a high `ovf` sends the next address to 17 instead of 5. Address 17 shows cause_we=1 and cause_val=12.
- R7: In every last word of an instruction (addresses 2, 3, 5, 7, 10, 12; seq_code=00, cond_code=10), a high `irq_pend` sends the next address to 18 instead of 0. Address 18 shows cause_we=1 and cause_val=0.
- R8: `irq_pend` has no effect in words whose cond_code is not 10. `ovf` has no effect in words whose cond_code is not 01. In those words the micro-PC follows the seq_code as in R3.
- R9: The control outputs always show the fields of the word at the current `upc`. The encodings are:
  - alu_op: 00 add, 01 sub, 10 func, 11 or.
  - src2_sel: 0 four, 1 rt, 2 extend, 3 zero-extend, 4 extend-shift.
  - dest_sel: 0 none, 1 rd←ALU, 2 rt←ALU, 3 rt←mem.
  - mem_op: 0 none, 1 read PC, 2 read ALU, 3 write ALU.
  - pc_wr: 0 none, 1 ALU, 2 ALU-out if zero, 3 jump.
- R10: The handler words 16, 17 and 18 carry seq_code=00 and cond_code=00. They always return to 0, whatever the flags show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction register |
| ovf | input | 1 | ALU overflow flag |
| irq_pend | input | 1 | Pending external interrupt flag |
| upc | output | UA_W (5) | Current micro-address |
| alu_op | output | 2 | ALU operation field |
| src1_sel | output | 1 | First ALU operand: 0 PC, 1 rs |
| src2_sel | output | 3 | Second ALU operand select |
| dest_sel | output | 2 | Register write destination |
| mem_op | output | 2 | Memory operation |
| ir_wr | output | 1 | Instruction register write |
| pc_wr | output | 2 | PC write mode |
| seq_code | output | 2 | Sequencing field of the current word |
| cond_code | output | 2 | Condition select: 00 none, 01 overflow, 10 interrupt |
| cause_we | output | 1 | Handler word active; write EPC, cause and vector |
| cause_val | output | 5 | Cause code to record |

## Verification
Inputs presented before a rising edge decide the micro-address loaded on that edge. The new `upc`, its control fields and any cause code all appear one cycle after the stimulus, with no further lag. The bench drives `opcode`, `ovf` and `irq_pend` on the falling edge and advances its behavioural model with those same values. On the next falling edge it compares `upc` and every control output with the model. Each comparison therefore sees exactly one register stage between a decision and its effect. Flags are held high across whole instructions, so that the words which must ignore them are compared in the same pass.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_OR = 2'd3} alu_e;
  typedef enum logic [2:0] {S2_FOUR = 3'd0, S2_RT = 3'd1, S2_EXT = 3'd2, S2_EXT0 = 3'd3,
                            S2_EXTSH = 3'd4, S2_R5 = 3'd5, S2_R6 = 3'd6, S2_R7 = 3'd7} src2_e;
  typedef enum logic [1:0] {DST_NONE = 2'd0, DST_RD_ALU = 2'd1, DST_RT_ALU = 2'd2, DST_RT_MEM = 2'd3} dest_e;
  typedef enum logic [1:0] {MEM_NONE = 2'd0, MEM_RD_PC = 2'd1, MEM_RD_ALU = 2'd2, MEM_WR_ALU = 2'd3} mem_e;
  typedef enum logic [1:0] {PCW_NONE = 2'd0, PCW_ALU = 2'd1, PCW_COND = 2'd2, PCW_JUMP = 2'd3} pcw_e;
  typedef enum logic [1:0] {SEQ_FETCH = 2'd0, SEQ_DISP = 2'd1, SEQ_INC = 2'd2, SEQ_RSVD = 2'd3} seq_e;
  typedef enum logic [1:0] {COND_NONE = 2'd0, COND_OVF = 2'd1, COND_IRQ = 2'd2, COND_RSVD = 2'd3} cond_e;
  typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_RI = 2'd1, EXC_OVF = 2'd2, EXC_INT = 2'd3} exc_e;

  typedef struct packed {
    alu_e  alu;
    logic  src1;
    src2_e src2;
    dest_e dest;
    mem_e  mem;
    logic  ir_wr;
    pcw_e  pcw;
    seq_e  seq;
    cond_e cond;
    exc_e  exc;
  } uword_t;

  // Micro-addresses of the control store
  localparam int A_FETCH  = 0;
  localparam int A_DECODE = 1;
  localparam int A_BEQ    = 2;
  localparam int A_JMP    = 3;
  localparam int A_RTYPE  = 4;
  localparam int A_RWB    = 5;
  localparam int A_ORI    = 6;
  localparam int A_OWB    = 7;
  localparam int A_LW     = 8;
  localparam int A_LMEM   = 9;
  localparam int A_LWB    = 10;
  localparam int A_SW     = 11;
  localparam int A_SMEM   = 12;
  localparam int A_TRP_RI = 16;
  localparam int A_TRP_OV = 17;
  localparam int A_TRP_IN = 18;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [4:0] CAUSE_INT = 5'd0;
  localparam logic [4:0] CAUSE_RI  = 5'd10;
  localparam logic [4:0] CAUSE_OVF = 5'd12;

  function automatic uword_t mk(alu_e a, logic s1, src2_e s2, dest_e d, mem_e m,
                                logic ir, pcw_e p, seq_e s, cond_e c, exc_e e);
    uword_t w;
    w.alu = a; w.src1 = s1; w.src2 = s2; w.dest = d; w.mem = m;
    w.ir_wr = ir; w.pcw = p; w.seq = s; w.cond = c; w.exc = e;
    return w;
  endfunction

  // Control store contents, one word per micro-address
  function automatic uword_t ucode_at(int a);
    case (a)
      A_FETCH:  return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_RD_PC,  1'b1, PCW_ALU,  SEQ_INC,   COND_NONE, EXC_NONE);
      A_DECODE: return mk(ALU_ADD,  1'b0, S2_EXTSH, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_DISP,  COND_NONE, EXC_NONE);
      A_BEQ:    return mk(ALU_SUB,  1'b1, S2_RT,    DST_NONE,   MEM_NONE,   1'b0, PCW_COND, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_JMP:    return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_NONE,   1'b0, PCW_JUMP, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_RTYPE:  return mk(ALU_FUNC, 1'b1, S2_RT,    DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_INC,   COND_OVF,  EXC_NONE);
      A_RWB:    return mk(ALU_FUNC, 1'b1, S2_RT,    DST_RD_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_ORI:    return mk(ALU_OR,   1'b1, S2_EXT0,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_INC,   COND_NONE, EXC_NONE);
      A_OWB:    return mk(ALU_OR,   1'b1, S2_EXT0,  DST_RT_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_LW:     return mk(ALU_ADD,  1'b1, S2_EXT,   DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_INC,   COND_NONE, EXC_NONE);
      A_LMEM:   return mk(ALU_ADD,  1'b1, S2_EXT,   DST_NONE,   MEM_RD_ALU, 1'b0, PCW_NONE, SEQ_INC,   COND_NONE, EXC_NONE);
      A_LWB:    return mk(ALU_ADD,  1'b1, S2_EXT,   DST_RT_MEM, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_SW:     return mk(ALU_ADD,  1'b1, S2_EXT,   DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_INC,   COND_NONE, EXC_NONE);
      A_SMEM:   return mk(ALU_ADD,  1'b1, S2_EXT,   DST_NONE,   MEM_WR_ALU, 1'b0, PCW_NONE, SEQ_FETCH, COND_IRQ,  EXC_NONE);
      A_TRP_RI: return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_NONE, EXC_RI);
      A_TRP_OV: return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_NONE, EXC_OVF);
      A_TRP_IN: return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_NONE, EXC_INT);
      default:  return mk(ALU_ADD,  1'b0, S2_FOUR,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH, COND_NONE, EXC_NONE);
    endcase
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);
  always_comb word = ucode_at(int'(addr));
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic [5:0]      opcode,
  output logic [UA_W-1:0] target
);
  always_comb begin
    case (opcode)
      OP_RTYPE: target = UA_W'(A_RTYPE);
      OP_BEQ:   target = UA_W'(A_BEQ);
      OP_ORI:   target = UA_W'(A_ORI);
      OP_LW:    target = UA_W'(A_LW);
      OP_SW:    target = UA_W'(A_SW);
      OP_JMP:   target = UA_W'(A_JMP);
      default:  target = UA_W'(A_TRP_RI);
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic [UA_W-1:0] upc,
  input  seq_e            seq,
  input  cond_e           cond,
  input  logic [UA_W-1:0] disp,
  input  logic            ovf,
  input  logic            irq_pend,
  output logic [UA_W-1:0] nxt
);
  logic            take;
  logic [UA_W-1:0] br_tgt;

  always_comb begin
    take   = (cond == COND_OVF && ovf) || (cond == COND_IRQ && irq_pend);
    br_tgt = (cond == COND_OVF) ? UA_W'(A_TRP_OV) : UA_W'(A_TRP_IN);
    case (seq)
      SEQ_DISP: nxt = disp;
      SEQ_INC:  nxt = upc + UA_W'(1);
      default:  nxt = '0;
    endcase
    if (take) nxt = br_tgt;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int UA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      opcode,
  input  logic            ovf,
  input  logic            irq_pend,
  output logic [UA_W-1:0] upc,
  output logic [1:0]      alu_op,
  output logic            src1_sel,
  output logic [2:0]      src2_sel,
  output logic [1:0]      dest_sel,
  output logic [1:0]      mem_op,
  output logic            ir_wr,
  output logic [1:0]      pc_wr,
  output logic [1:0]      seq_code,
  output logic [1:0]      cond_code,
  output logic            cause_we,
  output logic [4:0]      cause_val
);
  localparam uword_t RST_WORD = ucode_at(A_FETCH);

  logic [UA_W-1:0] upc_q, upc_nxt, disp_tgt;
  uword_t          word_q, word_nxt;

  useq_dispatch #(.UA_W(UA_W)) u_disp (.opcode(opcode), .target(disp_tgt));

  useq_next #(.UA_W(UA_W)) u_next (
    .upc(upc_q), .seq(word_q.seq), .cond(word_q.cond), .disp(disp_tgt),
    .ovf(ovf), .irq_pend(irq_pend), .nxt(upc_nxt)
  );

  // Store read on the next address so the word register tracks upc_q
  useq_rom #(.UA_W(UA_W)) u_rom (.addr(upc_nxt), .word(word_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      word_q <= RST_WORD;
    end else begin
      upc_q  <= upc_nxt;
      word_q <= word_nxt;
    end
  end

  assign upc       = upc_q;
  assign alu_op    = word_q.alu;
  assign src1_sel  = word_q.src1;
  assign src2_sel  = word_q.src2;
  assign dest_sel  = word_q.dest;
  assign mem_op    = word_q.mem;
  assign ir_wr     = word_q.ir_wr;
  assign pc_wr     = word_q.pcw;
  assign seq_code  = word_q.seq;
  assign cond_code = word_q.cond;
  assign cause_we  = (word_q.exc != EXC_NONE);

  always_comb begin
    case (word_q.exc)
      EXC_RI:  cause_val = CAUSE_RI;
      EXC_OVF: cause_val = CAUSE_OVF;
      default: cause_val = CAUSE_INT;
    endcase
  end
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int UA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      opcode,
  input logic            ovf,
  input logic            irq_pend,
  input logic [UA_W-1:0] upc,
  input logic [1:0]      seq_code,
  input logic [1:0]      cond_code,
  input logic            cause_we,
  input logic [4:0]      cause_val
);
  logic known_op;
  assign known_op = (opcode == 6'h00) || (opcode == 6'h04) || (opcode == 6'h0D) ||
                    (opcode == 6'h23) || (opcode == 6'h2B) || (opcode == 6'h02);

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == '0) |=> (upc == UA_W'(1)));

  // R3
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 2'b10 && cond_code == 2'b00) |=> (upc == $past(upc) + UA_W'(1)));

  // R5
  trap_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_W'(1) && !known_op) |=> (upc == UA_W'(16) && cause_we && cause_val == 5'd10));

  // R6
  ovf_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_W'(4) && ovf) |=> (upc == UA_W'(17) && cause_val == 5'd12));

  // R7
  irq_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 2'b00 && cond_code == 2'b10 && irq_pend) |=> (upc == UA_W'(18) && cause_we));

  // R10
  handler_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> (upc == '0));

  // R9
  always_comb begin
    if (rst_n && cause_we)
      cause_code_chk: assert (cause_val == 5'd0 || cause_val == 5'd10 || cause_val == 5'd12);
  end
endmodule

bind useq_ctrl useq_chk #(.UA_W(UA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .ovf(ovf), .irq_pend(irq_pend),
  .upc(upc), .seq_code(seq_code), .cond_code(cond_code),
  .cause_we(cause_we), .cause_val(cause_val)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
  localparam int UA_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic ovf = 1'b0, irq_pend = 1'b0;
  logic [UA_W-1:0] upc;
  logic [1:0] alu_op, dest_sel, mem_op, pc_wr, seq_code, cond_code;
  logic src1_sel, ir_wr, cause_we;
  logic [2:0] src2_sel;
  logic [4:0] cause_val;

  int checks = 0, errors = 0;
  int m_upc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  useq_ctrl #(.UA_W(UA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .ovf(ovf), .irq_pend(irq_pend),
    .upc(upc), .alu_op(alu_op), .src1_sel(src1_sel), .src2_sel(src2_sel),
    .dest_sel(dest_sel), .mem_op(mem_op), .ir_wr(ir_wr), .pc_wr(pc_wr),
    .seq_code(seq_code), .cond_code(cond_code), .cause_we(cause_we), .cause_val(cause_val)
  );

  // Expected controls per micro-address, laid out as
  // {alu,src1,src2,dest,mem,ir,pcw,seq,cond,cause_we,cause_val}
  function automatic logic [22:0] exp_ctrl(int a);
    case (a)
      0:  return {2'd0,1'b0,3'd0,2'd0,2'd1,1'b1,2'd1,2'd2,2'd0,1'b0,5'd0};
      1:  return {2'd0,1'b0,3'd4,2'd0,2'd0,1'b0,2'd0,2'd1,2'd0,1'b0,5'd0};
      2:  return {2'd1,1'b1,3'd1,2'd0,2'd0,1'b0,2'd2,2'd0,2'd2,1'b0,5'd0};
      3:  return {2'd0,1'b0,3'd0,2'd0,2'd0,1'b0,2'd3,2'd0,2'd2,1'b0,5'd0};
      4:  return {2'd2,1'b1,3'd1,2'd0,2'd0,1'b0,2'd0,2'd2,2'd1,1'b0,5'd0};
      5:  return {2'd2,1'b1,3'd1,2'd1,2'd0,1'b0,2'd0,2'd0,2'd2,1'b0,5'd0};
      6:  return {2'd3,1'b1,3'd3,2'd0,2'd0,1'b0,2'd0,2'd2,2'd0,1'b0,5'd0};
      7:  return {2'd3,1'b1,3'd3,2'd2,2'd0,1'b0,2'd0,2'd0,2'd2,1'b0,5'd0};
      8:  return {2'd0,1'b1,3'd2,2'd0,2'd0,1'b0,2'd0,2'd2,2'd0,1'b0,5'd0};
      9:  return {2'd0,1'b1,3'd2,2'd0,2'd2,1'b0,2'd0,2'd2,2'd0,1'b0,5'd0};
      10: return {2'd0,1'b1,3'd2,2'd3,2'd0,1'b0,2'd0,2'd0,2'd2,1'b0,5'd0};
      11: return {2'd0,1'b1,3'd2,2'd0,2'd0,1'b0,2'd0,2'd2,2'd0,1'b0,5'd0};
      12: return {2'd0,1'b1,3'd2,2'd0,2'd3,1'b0,2'd0,2'd0,2'd2,1'b0,5'd0};
      16: return {2'd0,1'b0,3'd0,2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b1,5'd10};
      17: return {2'd0,1'b0,3'd0,2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b1,5'd12};
      18: return {2'd0,1'b0,3'd0,2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b1,5'd0};
      default: return '1;
    endcase
  endfunction

  function automatic int disp_of(logic [5:0] op);
    case (op)
      6'h00: return 4;
      6'h04: return 2;
      6'h0D: return 6;
      6'h23: return 8;
      6'h2B: return 11;
      6'h02: return 3;
      default: return 16;
    endcase
  endfunction

  function automatic int model_next(int a, logic [5:0] op, logic ov, logic ir);
    case (a)
      0: return 1;
      1: return disp_of(op);
      4: return ov ? 17 : 5;
      2, 3, 5, 7, 10, 12: return ir ? 18 : 0;
      6, 8, 9, 11: return a + 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1: return "R4";
      16: return "R5";
      17: return "R6";
      18: return "R7";
      5, 7, 10, 12, 2, 3: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic check_all(string tag);
    logic [22:0] obs;
    obs = {alu_op, src1_sel, src2_sel, dest_sel, mem_op, ir_wr, pc_wr,
           seq_code, cond_code, cause_we, cause_val};
    checks++;
    if (int'(upc) != m_upc) begin
      errors++;
      $display("FAIL %s upc actual=%0d expected=%0d", tag, upc, m_upc);
    end
    checks++;
    if (obs !== exp_ctrl(m_upc)) begin
      errors++;
      $display("FAIL R9 controls at upc %0d actual=%h expected=%h", m_upc, obs, exp_ctrl(m_upc));
    end
  endtask

  // Drive inputs for one cycle; model advances with the same values
  task automatic step(logic [5:0] op, logic ov, logic ir);
    opcode = op; ovf = ov; irq_pend = ir;
    m_upc = model_next(m_upc, op, ov, ir);
    @(negedge clk);
    check_all(tag_of(m_upc));
  endtask

  // Run one instruction from fetch back to fetch with flags held
  task automatic run_instr(logic [5:0] op, logic ov, logic ir);
    for (int k = 0; k < 12; k++) begin
      step(op, ov, ir);
      if (m_upc == 0) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    m_upc = 0;
    // R4 / R2 / R3: each dispatched opcode, no flags
    run_instr(6'h00, 1'b0, 1'b0);
    run_instr(6'h04, 1'b0, 1'b0);
    run_instr(6'h0D, 1'b0, 1'b0);
    run_instr(6'h23, 1'b0, 1'b0);
    run_instr(6'h2B, 1'b0, 1'b0);
    run_instr(6'h02, 1'b0, 1'b0);
    // R5: unknown opcodes trap
    run_instr(6'h3F, 1'b0, 1'b0);
    run_instr(6'h01, 1'b0, 1'b0);
    // R6: overflow on R-type
    run_instr(6'h00, 1'b1, 1'b0);
    // R8: overflow held through ORI and LW has no effect
    run_instr(6'h0D, 1'b1, 1'b0);
    run_instr(6'h23, 1'b1, 1'b0);
    // R7 / R8: interrupt held through a whole SW, taken only at its last word
    run_instr(6'h2B, 1'b0, 1'b1);
    run_instr(6'h04, 1'b0, 1'b1);
    // R10: both flags high into a handler, still returns to 0
    run_instr(6'h00, 1'b1, 1'b1);
    run_instr(6'h11, 1'b1, 1'b1);
    // R1: reset in mid-instruction
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    m_upc = 0;
    check_all("R1");
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      case ($urandom % 8)
        0: op = 6'h00; 1: op = 6'h04; 2: op = 6'h0D; 3: op = 6'h23;
        4: op = 6'h2B; 5: op = 6'h02; 6: op = 6'($urandom); default: op = 6'h3E;
      endcase
      step(op, ($urandom % 4) == 0, ($urandom % 5) == 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule